// File: doc/BRIEF.md
# Fixed-Priority Interrupt Vector Controller

This block sits beside the fetch stage of a small 8-bit processor and decides, once per clock, whether an interrupt should be taken and where execution must go. It looks at the pending request flags of every source, an enable mask with one bit per source, and a global enable bit that the block holds itself. From these it picks the single winning source and produces the program address of that source's vector slot. It then raises a one-cycle strobe together with a one-hot acknowledge for the peripheral's flag, and drops the global enable so that the handler starts with interrupts off.

The vector table is built from two-word slots. Slot 0 holds the reset entry, and interrupt source `i` occupies slot `i+1`. The whole interrupt table can be moved to the start of the boot region with a select input. The reset entry is moved separately by a configuration bit. Two lock inputs mute interrupts depending on whether the current program counter lies in the application region or in the boot region. Reset cannot be masked: it wins over everything and presents the reset vector.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While `rst` is high, `taken_o`, `ack_o` and `gie_o` are 0 from the next clock edge onward, and `vec_o` equals the reset vector: 0 when `boot_rst_cfg` is 0, and `BOOT_START` (default 0xC00) when it is 1.
- R2: A source is served only when its `irq_req` bit, its `irq_en` bit and `gie_o` are all 1. A request that is blocked by the global enable or by its own enable stays unserved. It is served once the blocking bit becomes 1.
- R3: When several sources qualify, the lowest index wins. Source 0 has the highest interrupt priority.
- R4: The vector of source `i` is `base + 2*(i+1)`, where `base` is 0 when `vec_sel` is 0 and `BOOT_START` when it is 1. Slot 0 is left to the reset entry.
- R5: An entry is reported one clock edge after the cycle in which the source qualified. `taken_o` is high for one cycle, `ack_o` has exactly bit `i` set in that cycle and is all zeros otherwise, and `vec_o` carries the vector in the same cycle.
- R6: `gie_o` is written through `gie_wr`/`gie_wr_val` and is cleared at the same edge on which an entry is registered. If a write and an entry fall on the same edge, the entry wins.
- R7: With `lock_app` high, no entry is taken while `pc` is below `BOOT_START` (application region).
- R8: With `lock_boot` high, no entry is taken while `pc` is at or above `BOOT_START` (boot region).
- R9: Reset overrides pending interrupts. A request that qualifies in the cycle reset is asserted produces no entry, and requests still pending after reset stay unserved until software sets the global enable again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_SRC | Pending request flags, bit 0 = highest priority source |
| irq_en | input | NUM_SRC | Per-source enable mask |
| gie_wr | input | 1 | Write strobe for the global enable |
| gie_wr_val | input | 1 | Value written to the global enable |
| vec_sel | input | 1 | Moves the interrupt table to the boot region start |
| boot_rst_cfg | input | 1 | Moves the reset vector to the boot region start |
| lock_app | input | 1 | Mutes interrupts while executing in the application region |
| lock_boot | input | 1 | Mutes interrupts while executing in the boot region |
| pc | input | PC_W | Current program counter (word address) |
| taken_o | output | 1 | One-cycle interrupt entry strobe |
| vec_o | output | PC_W | Vector address (reset vector while in reset) |
| ack_o | output | NUM_SRC | One-hot clear for the served source's flag |
| gie_o | output | 1 | Current global enable |

## Verification
The bench targets the following corner cases:
- Several sources pending at once. A wrong priority encoder would acknowledge a higher-indexed source or an ack with more than one bit set.
- A source that is pending but masked while a lower-priority source is enabled. A design that skipped the mask would jump to the wrong slot, and one that dropped the request would never serve it after the mask opens.
- Each lock input tested on both sides of the region boundary, including the last application word and the first boot word. An off-by-one region compare shows up as an entry taken early or never.
- The table relocation, including the last source. A wrong base or a missing slot offset collides with the reset slot.
- Reset raised in the very cycle a request qualifies. A design that let the request through would emit a strobe or come out of reset with the global enable still set.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  // Width of a source index for a given source count (at least one bit).
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Each vector slot spans two program words; slot 0 is the reset entry.
  localparam int SLOT_WORDS = 2;

endpackage

// File: rtl/irqv_arbiter.sv
module irqv_arbiter #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = irqv_pkg::idx_width(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] cand,
  output logic               any_o,
  output logic [NUM_SRC-1:0] win_oh_o,
  output logic [IDX_W-1:0]   win_idx_o
);

  // blocked[i] is high when some lower-indexed (higher priority) source qualifies
  logic [NUM_SRC:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
    assign blocked[g+1] = blocked[g] | cand[g];
    assign win_oh_o[g]  = cand[g] & ~blocked[g];
  end

  assign any_o = blocked[NUM_SRC];

  always_comb begin
    win_idx_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (win_oh_o[i]) win_idx_o = IDX_W'(i);
    end
  end

  // R3: the grant never has more than one bit set
  always_comb begin
    assert_grant_single_R3: assert ($countones(win_oh_o) <= 1);
  end

endmodule

// File: rtl/irqv_region_gate.sv
module irqv_region_gate #(
  parameter int PC_W       = 12,
  parameter int BOOT_START = 'hC00
) (
  input  logic [PC_W-1:0] pc,
  input  logic            lock_app,
  input  logic            lock_boot,
  output logic            in_boot_o,
  output logic            mute_o
);

  localparam logic [PC_W-1:0] BOOT_ADDR = PC_W'(BOOT_START);

  assign in_boot_o = (pc >= BOOT_ADDR);
  // R7 / R8: each lock input mutes its own region only
  assign mute_o    = (lock_app & ~in_boot_o) | (lock_boot & in_boot_o);

endmodule

// File: rtl/irqv_vector_gen.sv
module irqv_vector_gen #(
  parameter int NUM_SRC    = 8,
  parameter int PC_W       = 12,
  parameter int BOOT_START = 'hC00,
  localparam int IDX_W = irqv_pkg::idx_width(NUM_SRC)
) (
  input  logic [IDX_W-1:0] win_idx,
  input  logic             vec_sel,
  input  logic             boot_rst_cfg,
  output logic [PC_W-1:0]  irq_vec_o,
  output logic [PC_W-1:0]  rst_vec_o
);

  localparam logic [PC_W-1:0] BOOT_ADDR = PC_W'(BOOT_START);
  localparam logic [PC_W-1:0] SLOT_SZ   = PC_W'(irqv_pkg::SLOT_WORDS);

  logic [PC_W-1:0] base;
  logic [PC_W-1:0] slot;

  assign base      = vec_sel ? BOOT_ADDR : '0;
  assign slot      = PC_W'(win_idx) + PC_W'(1);
  assign irq_vec_o = base + slot * SLOT_SZ;
  assign rst_vec_o = boot_rst_cfg ? BOOT_ADDR : '0;

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int NUM_SRC    = 8,
  parameter int PC_W       = 12,
  parameter int BOOT_START = 'hC00
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic [NUM_SRC-1:0] irq_en,
  input  logic               gie_wr,
  input  logic               gie_wr_val,
  input  logic               vec_sel,
  input  logic               boot_rst_cfg,
  input  logic               lock_app,
  input  logic               lock_boot,
  input  logic [PC_W-1:0]    pc,
  output logic               taken_o,
  output logic [PC_W-1:0]    vec_o,
  output logic [NUM_SRC-1:0] ack_o,
  output logic               gie_o
);

  localparam int IDX_W = irqv_pkg::idx_width(NUM_SRC);
  localparam logic [PC_W-1:0] BOOT_ADDR = PC_W'(BOOT_START);

  logic [NUM_SRC-1:0] cand;
  logic               any_c;
  logic [NUM_SRC-1:0] win_oh;
  logic [IDX_W-1:0]   win_idx;
  logic               in_boot;
  logic               mute;
  logic [PC_W-1:0]    irq_vec;
  logic [PC_W-1:0]    rst_vec;
  logic               accept;

  logic               taken_q;
  logic [PC_W-1:0]    vec_q;
  logic [NUM_SRC-1:0] ack_q;
  logic               gie_q;

  assign cand = irq_req & irq_en;

  irqv_arbiter #(.NUM_SRC(NUM_SRC)) arb_i (
    .cand      (cand),
    .any_o     (any_c),
    .win_oh_o  (win_oh),
    .win_idx_o (win_idx)
  );

  irqv_region_gate #(.PC_W(PC_W), .BOOT_START(BOOT_START)) gate_i (
    .pc        (pc),
    .lock_app  (lock_app),
    .lock_boot (lock_boot),
    .in_boot_o (in_boot),
    .mute_o    (mute)
  );

  irqv_vector_gen #(.NUM_SRC(NUM_SRC), .PC_W(PC_W), .BOOT_START(BOOT_START)) vgen_i (
    .win_idx      (win_idx),
    .vec_sel      (vec_sel),
    .boot_rst_cfg (boot_rst_cfg),
    .irq_vec_o    (irq_vec),
    .rst_vec_o    (rst_vec)
  );

  assign accept = gie_q & ~mute & any_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      taken_q <= 1'b0;
      ack_q   <= '0;
      gie_q   <= 1'b0;
      vec_q   <= rst_vec;
    end else begin
      taken_q <= accept;
      ack_q   <= accept ? win_oh : '0;
      if (accept) begin
        vec_q <= irq_vec;
        gie_q <= 1'b0;
      end else if (gie_wr) begin
        gie_q <= gie_wr_val;
      end
    end
  end

  assign taken_o = taken_q;
  assign vec_o   = vec_q;
  assign ack_o   = ack_q;
  assign gie_o   = gie_q;

  // R2: entry only with the global enable set in the previous cycle
  assert_entry_needs_gie_R2: assert property (@(posedge clk) disable iff (rst)
    taken_q |-> $past(gie_q));

  // R2: acknowledged source was pending and enabled
  assert_winner_enabled_R2: assert property (@(posedge clk) disable iff (rst)
    taken_q |-> ((ack_q & $past(irq_req & irq_en)) != '0));

  // R3: nothing of higher priority was pending and enabled
  assert_priority_R3: assert property (@(posedge clk) disable iff (rst)
    taken_q |-> (((ack_q - NUM_SRC'(1)) & $past(irq_req & irq_en)) == '0));

  // R5: one-hot ack with the strobe, silent otherwise
  assert_ack_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    taken_q |-> ($countones(ack_q) == 1));

  assert_ack_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !taken_q |-> (ack_q == '0));

  // R6: global enable drops on entry
  assert_gie_cleared_R6: assert property (@(posedge clk) disable iff (rst)
    taken_q |-> !gie_q);

  // R7 and R8: no entry out of a muted region
  assert_lock_gate_R7: assert property (@(posedge clk) disable iff (rst)
    taken_q |-> !$past(mute));

  // R4: relocated table lands in the boot region on an even word
  assert_vec_base_R4: assert property (@(posedge clk) disable iff (rst)
    (taken_q && $past(vec_sel)) |-> (vec_q >= BOOT_ADDR && vec_q[0] == 1'b0));

endmodule

// File: tb/irq_vector_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb_top;
  localparam int N    = 8;
  localparam int PW   = 12;
  localparam int BOOT = 'hC00;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1;
  logic [N-1:0]  irq_req = '0, irq_en = '0;
  logic          gie_wr = 1'b0, gie_wr_val = 1'b0;
  logic          vec_sel = 1'b0, boot_rst_cfg = 1'b0;
  logic          lock_app = 1'b0, lock_boot = 1'b0;
  logic [PW-1:0] pc = '0;
  logic          taken_o, gie_o;
  logic [PW-1:0] vec_o;
  logic [N-1:0]  ack_o;

  irq_vector_ctrl #(.NUM_SRC(N), .PC_W(PW), .BOOT_START(BOOT)) dut_i (
    .clk(clk), .rst(rst), .irq_req(irq_req), .irq_en(irq_en),
    .gie_wr(gie_wr), .gie_wr_val(gie_wr_val), .vec_sel(vec_sel),
    .boot_rst_cfg(boot_rst_cfg), .lock_app(lock_app), .lock_boot(lock_boot),
    .pc(pc), .taken_o(taken_o), .vec_o(vec_o), .ack_o(ack_o), .gie_o(gie_o)
  );

  int checks = 0, fails = 0, takes = 0;
  int            q_idx[$];
  logic [PW-1:0] q_vec[$];

  function automatic logic [PW-1:0] exp_vec(int idx, bit vs);
    return PW'((vs ? BOOT : 0) + 2 * (idx + 1));
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected entries as the design reports them
  always @(negedge clk) begin
    if (!rst && taken_o) begin
      takes++;
      if (q_idx.size() == 0) begin
        chk(1'b0, "R2", "unexpected entry vector", int'(vec_o), 0);
      end else begin
        int            e_idx;
        logic [PW-1:0] e_vec;
        e_idx = q_idx.pop_front();
        e_vec = q_vec.pop_front();
        chk(vec_o == e_vec, "R4", "vector", int'(vec_o), int'(e_vec));
        chk(ack_o == N'(1) << e_idx, "R5", "ack", int'(ack_o), 1 << e_idx);
      end
    end
  end

  task automatic push_exp(int idx, bit vs);
    q_idx.push_back(idx);
    q_vec.push_back(exp_vec(idx, vs));
  endtask

  task automatic set_gie(bit v);
    @(negedge clk);
    gie_wr = 1'b1; gie_wr_val = v;
    @(negedge clk);
    gie_wr = 1'b0;
  endtask

  task automatic wait_done(string tag);
    for (int k = 0; k < 10 && q_idx.size() != 0; k++) begin
      @(negedge clk); #1;
    end
    chk(q_idx.size() == 0, tag, "entry missing, queue depth", q_idx.size(), 0);
    chk(gie_o == 1'b0, "R6", "global enable after entry", int'(gie_o), 0);
    @(negedge clk); #1;
    chk(taken_o == 1'b0, "R5", "strobe width", int'(taken_o), 0);
  endtask

  task automatic expect_entry(int idx, bit vs, string tag);
    push_exp(idx, vs);
    set_gie(1'b1);
    wait_done(tag);
    irq_req[idx] = 1'b0;
  endtask

  task automatic quiet(int n, string tag);
    int t0 = takes;
    repeat (n) @(negedge clk);
    chk(takes == t0, tag, "entries while blocked", takes - t0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state and reset vector selection
    repeat (3) @(negedge clk);
    chk(vec_o == '0, "R1", "reset vector fuse=0", int'(vec_o), 0);
    chk(taken_o == 1'b0 && ack_o == '0, "R1", "strobe/ack in reset", int'(ack_o), 0);
    chk(gie_o == 1'b0, "R1", "gie in reset", int'(gie_o), 0);
    boot_rst_cfg = 1'b1;
    @(negedge clk);
    chk(vec_o == PW'(BOOT), "R1", "reset vector fuse=1", int'(vec_o), BOOT);
    boot_rst_cfg = 1'b0;
    @(negedge clk);
    rst = 1'b0;

    // R2: pending with gie off, then priority order R3
    irq_en  = '1;
    irq_req = 8'b0000_0101;
    quiet(4, "R2");
    expect_entry(0, 1'b0, "R3");
    expect_entry(2, 1'b0, "R3");

    // R2: masked higher-priority source does not win
    irq_req = 8'b0010_0010;
    irq_en  = 8'b0010_0000;
    expect_entry(5, 1'b0, "R2");
    set_gie(1'b1);
    quiet(4, "R2");
    push_exp(1, 1'b0);
    irq_en = '1;
    wait_done("R2");
    irq_req[1] = 1'b0;

    // R4: relocated table, including last source
    vec_sel = 1'b1;
    irq_req = 8'b0000_1000;
    expect_entry(3, 1'b1, "R4");
    irq_req = 8'b1000_0000;
    expect_entry(7, 1'b1, "R4");
    vec_sel = 1'b0;

    // R7: application-region lock, boundary at BOOT-1 / BOOT
    lock_app = 1'b1;
    pc = 12'h100;
    irq_req = 8'b0001_0000;
    set_gie(1'b1);
    quiet(4, "R7");
    pc = 12'hBFF;
    quiet(2, "R7");
    push_exp(4, 1'b0);
    pc = 12'hC00;
    wait_done("R7");
    irq_req[4] = 1'b0;
    lock_app = 1'b0;

    // R8: boot-region lock
    lock_boot = 1'b1;
    pc = 12'hC10;
    irq_req = 8'b0100_0000;
    set_gie(1'b1);
    quiet(4, "R8");
    push_exp(6, 1'b0);
    pc = 12'h050;
    wait_done("R8");
    irq_req[6] = 1'b0;
    lock_boot = 1'b0;

    // R6: software write of the global enable
    set_gie(1'b1);
    chk(gie_o == 1'b1, "R6", "gie after set", int'(gie_o), 1);
    set_gie(1'b0);
    chk(gie_o == 1'b0, "R6", "gie after clear", int'(gie_o), 0);

    // R9: reset in the cycle a request qualifies
    irq_req = 8'b1000_0001;
    boot_rst_cfg = 1'b1;
    @(negedge clk);
    gie_wr = 1'b1; gie_wr_val = 1'b1;
    @(negedge clk);
    gie_wr = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    chk(taken_o == 1'b0, "R9", "strobe under reset", int'(taken_o), 0);
    chk(vec_o == PW'(BOOT), "R9", "reset vector wins", int'(vec_o), BOOT);
    chk(gie_o == 1'b0, "R9", "gie after reset", int'(gie_o), 0);
    rst = 1'b0;
    boot_rst_cfg = 1'b0;
    quiet(4, "R9");
    expect_entry(0, 1'b0, "R9");
    expect_entry(7, 1'b0, "R3");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule